// File: doc/BRIEF.md
# Regulator Saturation Warning Monitor

This block watches the output value of a regulator and raises a warning when that value has stayed close to one of its limits for longer than a dwell time. A regulator that sits at a limit for a long time has lost its control range, so the warning tells the operator the loop is saturated. The warning is latched. An operator clears it with an acknowledge. A one-cycle event marks the moment it first appears, so an external logger can record it.

Proximity to a limit is judged in one of two ways. In absolute mode the low and high limits come in on ports, and a fixed margin is applied inward from each. In percentage mode the thresholds are fixed fractions of full scale: 2 % and 98 %. When the regulator drives pulse-type raise/lower outputs in place of the analog value, an inhibit input holds the monitor idle and the warning low.

Control is a three-state machine.
- IDLE: the value is away from both limits.
- TIMING: the value is near a limit and a dwell counter is running.
- ALARM: the warning is latched.

Transitions:
- IDLE to TIMING on "near".
- TIMING to IDLE on "left".
- TIMING to ALARM on "expired". This transition emits the event.
- ALARM to IDLE on "acknowledged": ack is high while the value is not near.
- Any state to IDLE on "inhibited".

Top module: `regsat_monitor`

## Requirements
- R1: In absolute mode (mode_pct_i = 0), the value is near the low limit when value_i <= lo_lim_i + MARGIN.
- R2: In absolute mode, the value is near the high limit when value_i >= hi_lim_i - MARGIN. When hi_lim_i < MARGIN the threshold saturates to 0.
- R3: In percentage mode (mode_pct_i = 1), the limits are ignored. The value is near when value_i < FS*2/100 or value_i > FS*98/100, with FS = 2^DATA_W - 1 and integer division.
- R4: warn_o rises at the clock edge that samples the near condition for the (DWELL_TICKS+1)-th consecutive time. It is low before that edge.
- R5: A single sampled cycle outside the band restarts the dwell count from zero.
- R6: warn_evt_o is high for exactly one cycle, namely the first cycle in which warn_o is high.
- R7: Once high, warn_o stays high even if the value leaves the band. ack_i is ignored while the value is near. warn_o goes low at the edge that samples ack_i = 1 with the value not near.
- R8: While inhibit_i is high, warn_o goes low at the next edge and stays low. The dwell count restarts from zero when inhibit_i is released.
- R9: After reset, warn_o and warn_evt_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| value_i | input | DATA_W | Regulator output value being watched |
| lo_lim_i | input | DATA_W | Low limit, used in absolute mode |
| hi_lim_i | input | DATA_W | High limit, used in absolute mode |
| mode_pct_i | input | 1 | 0 = absolute band, 1 = percentage band |
| inhibit_i | input | 1 | High when pulse outputs replace the analog value; blocks the warning |
| ack_i | input | 1 | Acknowledge that clears a latched warning |
| warn_o | output | 1 | Latched saturation warning |
| warn_evt_o | output | 1 | One-cycle pulse on the first cycle of a warning |

## Verification
The bench probes each threshold one code inside and one code outside the band, in both modes. A comparator with an off-by-one error, or one that used a strict compare where an inclusive one is needed, would raise or miss the warning there. It also probes the saturated high threshold; a design that underflowed would never see the value as near. For the dwell, the bench samples the warning one edge before and at the expected rise, and it inserts a single out-of-band cycle into a run. A counter that was off by one, or that paused instead of restarting, would warn early or late. For the latch, the bench acknowledges while the value is still near, and it drops inhibit in mid-dwell. A latch that cleared too easily, or an inhibit that failed to restart the count, would show up as a wrong warning level at a known edge.

// File: rtl/regsat_pkg.sv
package regsat_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TIMING = 2'd1,
        ST_ALARM  = 2'd2
    } mon_state_t;

endpackage

// File: rtl/regsat_band.sv
module regsat_band #(
    parameter int DATA_W = 12,
    parameter int MARGIN = 41
) (
    input  logic [DATA_W-1:0] value_i,
    input  logic [DATA_W-1:0] lo_lim_i,
    input  logic [DATA_W-1:0] hi_lim_i,
    input  logic              mode_pct_i,
    output logic              near_o
);
    localparam longint FULL_SCALE = (longint'(1) << DATA_W) - 1;
    localparam logic [DATA_W-1:0] PCT_LO = DATA_W'((FULL_SCALE * 2) / 100);
    localparam logic [DATA_W-1:0] PCT_HI = DATA_W'((FULL_SCALE * 98) / 100);
    localparam logic [DATA_W:0]   MARG_W = (DATA_W+1)'(MARGIN);

    logic [DATA_W:0] val_w;
    logic [DATA_W:0] lo_thr;
    logic [DATA_W:0] hi_thr;
    logic            near_abs;
    logic            near_pct;

    always_comb begin
        val_w  = {1'b0, value_i};
        lo_thr = {1'b0, lo_lim_i} + MARG_W;
        if ({1'b0, hi_lim_i} >= MARG_W) begin
            hi_thr = {1'b0, hi_lim_i} - MARG_W;
        end else begin
            hi_thr = '0;
        end
        near_abs = (val_w <= lo_thr) || (val_w >= hi_thr);
        near_pct = (value_i < PCT_LO) || (value_i > PCT_HI);
        near_o   = mode_pct_i ? near_pct : near_abs;
    end

endmodule

// File: rtl/regsat_dwell.sv
module regsat_dwell #(
    parameter int DWELL_TICKS = 250_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en_i,
    output logic expired_o
);
    localparam int CNT_W = $clog2(DWELL_TICKS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DWELL_TICKS);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!count_en_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = (cnt_q == LIMIT);

    // R5: a cycle without counting leaves the timer not expired
    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !count_en_i |=> !expired_o);

endmodule

// File: rtl/regsat_fsm.sv
module regsat_fsm
    import regsat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic near_i,
    input  logic inhibit_i,
    input  logic ack_i,
    input  logic expired_i,
    output logic count_en_o,
    output logic warn_o,
    output logic warn_evt_o
);
    mon_state_t state_q;
    mon_state_t state_d;
    logic       go_alarm;

    always_comb begin
        state_d  = state_q;
        go_alarm = 1'b0;
        if (inhibit_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (near_i) state_d = ST_TIMING;
                end
                ST_TIMING: begin
                    if (!near_i) begin
                        state_d = ST_IDLE;
                    end else if (expired_i) begin
                        state_d  = ST_ALARM;
                        go_alarm = 1'b1;
                    end
                end
                ST_ALARM: begin
                    if (ack_i && !near_i) state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warn_o     <= 1'b0;
            warn_evt_o <= 1'b0;
        end else begin
            warn_o     <= (state_d == ST_ALARM);
            warn_evt_o <= go_alarm;
        end
    end

    assign count_en_o = near_i && !inhibit_i && (state_q != ST_ALARM);

    // R7: latched alarm holds without an acknowledge
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ALARM && !ack_i && !inhibit_i) |=> (state_q == ST_ALARM));

    // R7: acknowledge ignored while value still near
    a_r7_ack_near: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ALARM && ack_i && near_i && !inhibit_i) |=> warn_o);

endmodule

// File: rtl/regsat_monitor.sv
module regsat_monitor #(
    parameter int DATA_W      = 12,
    parameter int MARGIN      = 41,
    parameter int DWELL_TICKS = 250_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] value_i,
    input  logic [DATA_W-1:0] lo_lim_i,
    input  logic [DATA_W-1:0] hi_lim_i,
    input  logic              mode_pct_i,
    input  logic              inhibit_i,
    input  logic              ack_i,
    output logic              warn_o,
    output logic              warn_evt_o
);
    logic near;
    logic count_en;
    logic expired;

    regsat_band #(
        .DATA_W (DATA_W),
        .MARGIN (MARGIN)
    ) u_band (
        .value_i    (value_i),
        .lo_lim_i   (lo_lim_i),
        .hi_lim_i   (hi_lim_i),
        .mode_pct_i (mode_pct_i),
        .near_o     (near)
    );

    regsat_dwell #(
        .DWELL_TICKS (DWELL_TICKS)
    ) u_dwell (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_en_i (count_en),
        .expired_o  (expired)
    );

    regsat_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .near_i     (near),
        .inhibit_i  (inhibit_i),
        .ack_i      (ack_i),
        .expired_i  (expired),
        .count_en_o (count_en),
        .warn_o     (warn_o),
        .warn_evt_o (warn_evt_o)
    );

    // R6: event marks exactly the first warning cycle
    a_r6_evt_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warn_o) |-> warn_evt_o);
    a_r6_evt_only_rise: assert property (@(posedge clk) disable iff (!rst_n)
        warn_evt_o |-> $rose(warn_o));

    // R8: inhibit clears the warning at the next edge
    a_r8_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_i |=> !warn_o);

    // R4: warning can only rise after a near sample
    a_r4_rise_near: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warn_o) |-> $past(near));

endmodule

// File: tb/regsat_monitor_bench.sv
`timescale 1ns/1ps
module regsat_monitor_bench;
    localparam int DATA_W = 12;
    localparam int MARGIN = 41;
    localparam int DWELL  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DATA_W-1:0] value_i = 12'd2000;
    logic [DATA_W-1:0] lo_lim_i = 12'd1000;
    logic [DATA_W-1:0] hi_lim_i = 12'd3000;
    logic              mode_pct_i = 1'b0;
    logic              inhibit_i = 1'b0;
    logic              ack_i = 1'b0;
    logic              warn_o;
    logic              warn_evt_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    regsat_monitor #(
        .DATA_W (DATA_W),
        .MARGIN (MARGIN),
        .DWELL_TICKS (DWELL)
    ) u_regsat_monitor (
        .clk        (clk),
        .rst_n      (rst_n),
        .value_i    (value_i),
        .lo_lim_i   (lo_lim_i),
        .hi_lim_i   (hi_lim_i),
        .mode_pct_i (mode_pct_i),
        .inhibit_i  (inhibit_i),
        .ack_i      (ack_i),
        .warn_o     (warn_o),
        .warn_evt_o (warn_evt_o)
    );

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    task automatic idle_state;
        mode_pct_i = 1'b0; lo_lim_i = 12'd1000; hi_lim_i = 12'd3000;
        value_i = 12'd2000; ack_i = 1'b0;
        inhibit_i = 1'b1; step(1);
        inhibit_i = 1'b0; step(1);
    endtask

    // near for DWELL+1 samples: returns levels before and at the rise
    task automatic dwell_probe(input string req, input logic expect_near);
        step(DWELL);
        chk({req, " before dwell"}, warn_o, 1'b0);
        step(1);
        chk({req, " at dwell"}, warn_o, expect_near);
    endtask

    task automatic t_reset;
        chk("R9 warn", warn_o, 1'b0);
        chk("R9 evt", warn_evt_o, 1'b0);
    endtask

    task automatic t_abs_low;
        idle_state();
        value_i = 12'd1041;
        dwell_probe("R1 R4 low edge", 1'b1);
        chk("R6 evt first", warn_evt_o, 1'b1);
        step(1);
        chk("R6 evt once", warn_evt_o, 1'b0);
        chk("R7 still warn", warn_o, 1'b1);
        idle_state();
        value_i = 12'd1042;
        step(DWELL + 4);
        chk("R1 outside low", warn_o, 1'b0);
    endtask

    task automatic t_abs_high;
        idle_state();
        value_i = 12'd2959;
        dwell_probe("R2 high edge", 1'b1);
        idle_state();
        value_i = 12'd2958;
        step(DWELL + 4);
        chk("R2 outside high", warn_o, 1'b0);
        idle_state();
        hi_lim_i = 12'd20; value_i = 12'd2500;
        dwell_probe("R2 saturated threshold", 1'b1);
    endtask

    task automatic t_pct;
        idle_state();
        mode_pct_i = 1'b1; value_i = 12'd80;
        dwell_probe("R3 low pct", 1'b1);
        idle_state();
        mode_pct_i = 1'b1; value_i = 12'd81;
        step(DWELL + 4);
        chk("R3 low pct outside", warn_o, 1'b0);
        idle_state();
        mode_pct_i = 1'b1; value_i = 12'd4014;
        dwell_probe("R3 high pct", 1'b1);
        idle_state();
        mode_pct_i = 1'b1; value_i = 12'd4013;
        step(DWELL + 4);
        chk("R3 high pct outside", warn_o, 1'b0);
        idle_state();
        mode_pct_i = 1'b1; value_i = 12'd1000;
        step(DWELL + 4);
        chk("R3 limits ignored", warn_o, 1'b0);
    endtask

    task automatic t_restart;
        idle_state();
        value_i = 12'd500;
        step(DWELL);
        value_i = 12'd2000;
        step(1);
        value_i = 12'd500;
        dwell_probe("R5 restart", 1'b1);
    endtask

    task automatic t_latch;
        idle_state();
        value_i = 12'd500;
        step(DWELL + 1);
        chk("R7 set", warn_o, 1'b1);
        ack_i = 1'b1; step(1); ack_i = 1'b0;
        chk("R7 ack ignored near", warn_o, 1'b1);
        value_i = 12'd2000;
        step(3);
        chk("R7 hold out of band", warn_o, 1'b1);
        ack_i = 1'b1; step(1); ack_i = 1'b0;
        chk("R7 ack clears", warn_o, 1'b0);
        chk("R7 no evt on clear", warn_evt_o, 1'b0);
    endtask

    task automatic t_inhibit;
        idle_state();
        value_i = 12'd500; inhibit_i = 1'b1;
        step(DWELL + 6);
        chk("R8 blocked", warn_o, 1'b0);
        inhibit_i = 1'b0;
        dwell_probe("R8 restart after release", 1'b1);
        inhibit_i = 1'b1; step(1);
        chk("R8 clears alarm", warn_o, 1'b0);
        inhibit_i = 1'b0; step(1);
        chk("R8 no relatch", warn_o, 1'b0);
    endtask

    initial begin
        step(2);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_abs_low();
        t_abs_high();
        t_pct();
        t_restart();
        t_latch();
        t_inhibit();
        finish_run();
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

endmodule